// File: doc/BRIEF.md
# Configuration Restart and Revision Selector

This block starts a configuration load of a programmable logic device from a serial configuration memory. A load is started by one of three events. The first is the release of reset at power-up. The second is an external active-low program pulse. The third is a one-cycle configure command coming from a debug port. For a command, or at power-up, the block drives its own active-low restart line for a fixed time. The length of that time comes from the clock frequency and lies in the 300 to 500 ns window.

The restart line as seen by the block is the AND of its own driver and the synchronized external program input. Only the rising edge of that combined line samples which stored design revision to load. The revision comes from the external select pins or from internal revision bits, and a mode input chooses between them. A programmable per-revision table gives the first 8-Mbit unit of the revision, which can be any consecutive run of units. The block turns that unit into a bit address and tells the read engine to begin with a single-cycle start strobe.

Top module: `cfg_restart_ctrl`

## Requirements
- R1: After reset is released, `restart_n` stays low for exactly PULSE_CYC clock cycles and then goes high. PULSE_CYC = CLK_MHZ*400/1000, which is 100 cycles at 250 MHz. The revision is then sampled as for any other load.
- R2: A `cfg_cmd` strobe that arrives while `restart_n` is high drives `restart_n` low from the next clock edge for exactly PULSE_CYC cycles. It then releases the line high.
- R3: A `cfg_cmd` strobe that arrives while `restart_n` is low is ignored. The current pulse keeps exactly PULSE_CYC low cycles, and no second pulse follows.
- R4: `rev_out` changes only on a rising edge of the combined restart line (`restart_n` AND the synchronized `prog_n_in`). Changes of the select inputs at any other time leave `rev_out` unchanged.
- R5: With `use_pins`=1 the sampled revision is `rev_pins`, after a two-flop synchronizer. With `use_pins`=0 it is `rev_bits`.
- R6: A low pulse on `prog_n_in` starts a load. It passes through a two-flop synchronizer and the rising edge samples the revision. `load_start` is high in the 4th cycle after the clock edge at which `prog_n_in` rose.
- R7: `start_addr` equals the start unit stored for the latched revision times 2^23. It is a bit address.
- R8: `rev_out` and `start_addr` update on the clock edge after the rising edge of the combined line. `load_start` is high for exactly one cycle, in the cycle after that update.
- R9: If the sampled revision's table entry has valid=0, `load_start` stays low and `rev_err` goes to 1. `rev_err` returns to 0 at the next sample of a valid entry.
- R10: A write with `tbl_we`=1 stores `tbl_vld` and `tbl_unit` for revision `tbl_rev`. After reset, revision i holds unit i and is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cfg_cmd | input | 1 | One-cycle configure command from the debug port |
| prog_n_in | input | 1 | External active-low program line, asynchronous |
| rev_pins | input | REV_W | External revision select pins, asynchronous |
| rev_bits | input | REV_W | Internally programmed revision bits |
| use_pins | input | 1 | 1: select from pins, 0: select from internal bits |
| tbl_we | input | 1 | Revision table write enable |
| tbl_rev | input | REV_W | Revision entry to write |
| tbl_vld | input | 1 | Valid flag to write |
| tbl_unit | input | UNIT_W | Start unit index to write |
| restart_n | output | 1 | Self-generated active-low restart pulse |
| rev_out | output | REV_W | Latched revision |
| start_addr | output | ADDR_W | Bit start address of the latched revision |
| load_start | output | 1 | One-cycle strobe to start the read engine |
| rev_err | output | 1 | Latched revision is marked unused |

## Verification
A pulse counter in the wrong state shows up at once on `restart_n`. The bench sees a low time other than PULSE_CYC, or a pulse stretched by a second command, within one pulse length. A wrong edge detector or wrong select source shows up within two cycles of the line rising, as a wrong `rev_out`, `start_addr` or `rev_err`. It can also show up as a missing, doubled or misplaced `load_start`. A revision latched at the wrong time shows up as `rev_out` changing while the select inputs are changed between loads.

// File: rtl/cfg_restart_pkg.sv
package cfg_restart_pkg;
    localparam int DEF_CLK_MHZ   = 100;
    localparam int DEF_PULSE_NS  = 400;
    localparam int DEF_NUM_REVS  = 4;
    localparam int DEF_NUM_UNITS = 4;
    localparam int DEF_UNIT_BITS = 8388608;

    typedef enum logic {
        SRC_BITS = 1'b0,
        SRC_PINS = 1'b1
    } rev_src_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/cfg_pulse_gen.sv
module cfg_pulse_gen #(
    parameter int PULSE_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic             drv_n;
        logic [CNT_W-1:0] cnt;
    } pg_st_t;

    pg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.drv_n) begin
            if (st_q.cnt == '0) st_d.drv_n = 1'b1;
            else                st_d.cnt   = st_q.cnt - 1'b1;
        end else if (trig) begin
            st_d.drv_n = 1'b0;
            st_d.cnt   = CNT_W'(PULSE_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drv_n <= 1'b0;
            st_q.cnt   <= CNT_W'(PULSE_CYC - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_n = st_q.drv_n;

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.drv_n && st_q.cnt == '0) |=> st_q.drv_n);

    p_no_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.drv_n && st_q.cnt != '0) |=> (!st_q.drv_n && st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/cfg_rev_table.sv
module cfg_rev_table #(
    parameter int NUM_REVS  = 4,
    parameter int NUM_UNITS = 4,
    parameter int REV_W     = 2,
    parameter int UNIT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REV_W-1:0]  wr_rev,
    input  logic              wr_vld,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic [REV_W-1:0]  rd_rev,
    output logic              rd_vld,
    output logic [UNIT_W-1:0] rd_unit
);
    typedef struct packed {
        logic              vld;
        logic [UNIT_W-1:0] unit;
    } ent_t;

    ent_t [NUM_REVS-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_rev].vld  = wr_vld;
            tbl_d[wr_rev].unit = wr_unit;
        end
    end

    for (genvar g = 0; g < NUM_REVS; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[g].vld  <= 1'b1;
                tbl_q[g].unit <= UNIT_W'(g % NUM_UNITS);
            end else begin
                tbl_q[g] <= tbl_d[g];
            end
        end
    end

    assign rd_vld  = tbl_q[rd_rev].vld;
    assign rd_unit = tbl_q[rd_rev].unit;
endmodule

// File: rtl/cfg_restart_ctrl.sv
module cfg_restart_ctrl
    import cfg_restart_pkg::*;
#(
    parameter int CLK_MHZ   = DEF_CLK_MHZ,
    parameter int PULSE_NS  = DEF_PULSE_NS,
    parameter int NUM_REVS  = DEF_NUM_REVS,
    parameter int NUM_UNITS = DEF_NUM_UNITS,
    parameter int UNIT_BITS = DEF_UNIT_BITS,
    parameter int REV_W     = $clog2(NUM_REVS),
    parameter int UNIT_W    = $clog2(NUM_UNITS),
    parameter int ADDR_W    = $clog2(NUM_UNITS) + $clog2(UNIT_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cmd,
    input  logic              prog_n_in,
    input  logic [REV_W-1:0]  rev_pins,
    input  logic [REV_W-1:0]  rev_bits,
    input  logic              use_pins,
    input  logic              tbl_we,
    input  logic [REV_W-1:0]  tbl_rev,
    input  logic              tbl_vld,
    input  logic [UNIT_W-1:0] tbl_unit,
    output logic              restart_n,
    output logic [REV_W-1:0]  rev_out,
    output logic [ADDR_W-1:0] start_addr,
    output logic              load_start,
    output logic              rev_err
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_NS / 1000;
    localparam int UNIT_SH   = $clog2(UNIT_BITS);
    localparam int SYNC_W    = REV_W + 1;

    typedef struct packed {
        logic              line_prev;
        logic [REV_W-1:0]  rev;
        logic [ADDR_W-1:0] addr;
        logic              err;
        logic              pend;
        logic              start;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [SYNC_W-1:0] sync_out;
    logic              prog_s;
    logic [REV_W-1:0]  pins_s;
    logic              pulse_n;
    logic              line;
    logic              rise;
    logic [REV_W-1:0]  sel;
    logic              rd_vld;
    logic [UNIT_W-1:0] rd_unit;
    rev_src_e          src;

    cfg_sync #(
        .W       (SYNC_W),
        .RST_VAL ({1'b1, {REV_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({prog_n_in, rev_pins}),
        .dout  (sync_out)
    );

    assign prog_s = sync_out[SYNC_W-1];
    assign pins_s = sync_out[REV_W-1:0];

    cfg_pulse_gen #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (cfg_cmd),
        .pulse_n (pulse_n)
    );

    assign src = rev_src_e'(use_pins);
    assign sel = (src == SRC_PINS) ? pins_s : rev_bits;

    cfg_rev_table #(
        .NUM_REVS  (NUM_REVS),
        .NUM_UNITS (NUM_UNITS),
        .REV_W     (REV_W),
        .UNIT_W    (UNIT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_rev  (tbl_rev),
        .wr_vld  (tbl_vld),
        .wr_unit (tbl_unit),
        .rd_rev  (sel),
        .rd_vld  (rd_vld),
        .rd_unit (rd_unit)
    );

    assign line = pulse_n & prog_s;
    assign rise = line & ~st_q.line_prev;

    always_comb begin
        st_d           = st_q;
        st_d.line_prev = line;
        st_d.start     = st_q.pend;
        st_d.pend      = 1'b0;
        if (rise) begin
            st_d.rev  = sel;
            st_d.addr = ADDR_W'(rd_unit) << UNIT_SH;
            st_d.err  = ~rd_vld;
            st_d.pend = rd_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart_n  = pulse_n;
    assign rev_out    = st_q.rev;
    assign start_addr = st_q.addr;
    assign load_start = st_q.start;
    assign rev_err    = st_q.err;

    p_rev_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.rev));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start);

    p_strobe_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> $past(rise, 2));

    p_err_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> !st_q.start);
endmodule

// File: tb/cfg_restart_ctrl_bench.sv
module cfg_restart_ctrl_bench;
    localparam int CLK_MHZ = 250;
    localparam int P       = CLK_MHZ * 400 / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cmd = 1'b0;
    logic       prog_n_in = 1'b1;
    logic [1:0] rev_pins = 2'd0;
    logic [1:0] rev_bits = 2'd2;
    logic       use_pins = 1'b0;
    logic       tbl_we = 1'b0;
    logic [1:0] tbl_rev = 2'd0;
    logic       tbl_vld = 1'b0;
    logic [1:0] tbl_unit = 2'd0;
    logic        restart_n;
    logic [1:0]  rev_out;
    logic [24:0] start_addr;
    logic        load_start;
    logic        rev_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit sh_vld [4];
    int sh_unit [4];

    always #2 clk = ~clk;

    cfg_restart_ctrl #(.CLK_MHZ(CLK_MHZ)) u_cfg_restart_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_cmd(cfg_cmd), .prog_n_in(prog_n_in),
        .rev_pins(rev_pins), .rev_bits(rev_bits), .use_pins(use_pins),
        .tbl_we(tbl_we), .tbl_rev(tbl_rev), .tbl_vld(tbl_vld), .tbl_unit(tbl_unit),
        .restart_n(restart_n), .rev_out(rev_out), .start_addr(start_addr),
        .load_start(load_start), .rev_err(rev_err)
    );

    function automatic longint exp_addr(int unit);
        return longint'(unit) * 64'd8388608;
    endfunction

    function automatic int exp_sel();
        return use_pins ? int'(rev_pins) : int'(rev_bits);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tbl_write(int r, bit v, int u);
        @(negedge clk);
        tbl_we = 1'b1; tbl_rev = 2'(r); tbl_vld = v; tbl_unit = 2'(u);
        @(negedge clk);
        tbl_we = 1'b0;
        sh_vld[r] = v; sh_unit[r] = u;
    endtask

    // called at the first negedge where the combined line is high again
    task automatic finish_load(int er, string req);
        longint old_rev;
        old_rev = longint'(rev_out);
        check("R8 no early latch", longint'(rev_out), old_rev);
        check("R8 no early start", longint'(load_start), 0);
        @(negedge clk);
        check({req, " R5 rev"}, longint'(rev_out), longint'(er));
        check("R9 err flag", longint'(rev_err), longint'(!sh_vld[er]));
        if (sh_vld[er]) check("R7 start_addr", longint'(start_addr), exp_addr(sh_unit[er]));
        check("R8 start not yet", longint'(load_start), 0);
        @(negedge clk);
        check("R8 R9 start strobe", longint'(load_start), longint'(sh_vld[er]));
        @(negedge clk);
        check("R8 single strobe", longint'(load_start), 0);
        // R4: change selection away from a load
        rev_bits = ~rev_bits; rev_pins = ~rev_pins;
        repeat (5) @(negedge clk);
        check("R4 rev held", longint'(rev_out), longint'(er));
        check("R3 no second pulse", longint'(restart_n), 1);
    endtask

    task automatic run_cmd(bit mid, int mid_at);
        int low;
        int er;
        er = exp_sel();
        @(negedge clk); cfg_cmd = 1'b1;
        @(negedge clk); cfg_cmd = 1'b0;
        low = 0;
        while (!restart_n && low < 2 * P) begin
            low++;
            cfg_cmd = (mid && low == mid_at);
            @(negedge clk);
        end
        cfg_cmd = 1'b0;
        check(mid ? "R3 pulse width with extra cmd" : "R2 pulse width", longint'(low), longint'(P));
        finish_load(er, "R2");
    endtask

    task automatic run_prog();
        int er;
        int seen;
        int k;
        er = exp_sel();
        @(negedge clk); prog_n_in = 1'b0;
        repeat (5) @(negedge clk);
        prog_n_in = 1'b1;
        seen = 0;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (load_start && seen == 0) seen = j;
        end
        k = sh_vld[er] ? 4 : 0;
        check("R6 start cycle after program release", longint'(seen), longint'(k));
        check("R6 rev", longint'(rev_out), longint'(er));
        check("R9 err after program", longint'(rev_err), longint'(!sh_vld[er]));
        if (sh_vld[er]) check("R7 addr after program", longint'(start_addr), exp_addr(sh_unit[er]));
    endtask

    initial begin
        int low;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4; i++) begin sh_vld[i] = 1'b1; sh_unit[i] = i; end
        repeat (3) @(negedge clk);
        check("R1 reset restart_n", longint'(restart_n), 0);
        check("R1 reset start", longint'(load_start), 0);
        check("R1 reset err", longint'(rev_err), 0);
        rst_n = 1'b1;
        low = 0;
        while (!restart_n && low < 2 * P) begin low++; @(negedge clk); end
        check("R1 power-up pulse width", longint'(low), longint'(P));
        finish_load(2, "R1");

        // directed: R10 table write, R9 unused entry
        tbl_write(3, 1'b0, 1);
        use_pins = 1'b0; rev_bits = 2'd3;
        run_cmd(1'b0, 0);
        tbl_write(1, 1'b1, 2);
        use_pins = 1'b1; rev_pins = 2'd1;
        run_cmd(1'b1, P);
        tbl_write(0, 1'b1, 3);
        use_pins = 1'b0; rev_bits = 2'd0;
        run_cmd(1'b1, 1);
        use_pins = 1'b1; rev_pins = 2'd3;
        run_prog();
        use_pins = 1'b1; rev_pins = 2'd1;
        run_prog();

        for (int it = 0; it < 24; it++) begin
            if ($urandom % 2 == 0)
                tbl_write(int'($urandom % 4), ($urandom % 4) != 0, int'($urandom % 4));
            use_pins = 1'($urandom % 2);
            rev_pins = 2'($urandom % 4);
            rev_bits = 2'($urandom % 4);
            repeat (3) @(negedge clk);
            if ($urandom % 4 == 0) run_prog();
            else run_cmd(1'($urandom % 2), 1 + int'($urandom % P));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule